// File: doc/BRIEF.md
# Serialized Interrupt Host Controller

This block is the host-side master of a single-wire, shared, active-low interrupt line. It opens each round with a start frame. It then walks a fixed series of three-clock data frames, sampling the line once per frame to rebuild a parallel vector of interrupt request levels and a system-management flag. Peripherals pull the line low in their own frame's sample clock to report an active request. A pull-up holds the line high when no agent drives it.

Two configuration inputs shape the start frame. `cfg_quiet` selects one of two modes. In host-paced (continuous) mode the controller begins every start frame itself. In wake-up (quiet) mode the controller waits for a peripheral to pull the line low for one clock, then takes over and finishes the start frame. `cfg_ext` sets the number of clocks the host adds to the low time. After reset the controller always begins the first start frame itself.

The state machine has six states:

- `ST_IDLE`: the line is released.
  - In host-paced mode it leaves for `ST_LOW` when the gap counter reaches zero.
  - In wake-up mode it leaves for `ST_LOW` when a low level is seen on the line.
- `ST_LOW`: the host drives the line low. It moves to `ST_HIGH` when the low counter reaches zero.
- `ST_HIGH`: the host drives the line high for one clock, then moves to `ST_SAMPLE`.
- `ST_SAMPLE`: the line is captured for the current frame. It moves to `ST_RECOV`.
- `ST_RECOV`: the recovery clock. It moves to `ST_TURN`.
- `ST_TURN`: the turn-around clock.
  - If this is not the last frame, it moves back to `ST_SAMPLE` and advances the frame index.
  - On the last frame it moves to `ST_IDLE` and commits the captured vector to the outputs.

Top module: `sirq_host`

## Requirements
- R1: While reset is asserted, `line_oe`, `irq_vec` and `smi_flag` are 0. The host begins the first start frame without a wake-up, even with `cfg_quiet` = 1. The line is released for exactly one clock after reset deassertion, and then the host low period starts.
- R2: In host-paced mode (`cfg_quiet` = 0) the host drives the line low (`line_oe` = 1, `line_out` = 0) for E+1 consecutive clocks. E is the effective extension value.
- R3: In wake-up mode (`cfg_quiet` = 1), a clock in `ST_IDLE` that sees the line low makes the host drive low from the next clock for exactly E clocks. With the peripheral's clock, the total low time is E+1.
- R4: The effective extension E equals `cfg_ext` clamped to the range 3..7. The raw values 0, 1 and 2 behave as 3, so the total low time always lies between 4 and 8 clocks.
- R5: Directly after the low period the host drives the line high (`line_oe` = 1, `line_out` = 1) for exactly one clock. It releases the line (`line_oe` = 0) in the clock that follows.
- R6: Frame n (n = 1..16) is sampled in the clock 1+3(n-1) after the host-high clock, which is 2+3(n-1) clocks after the last low clock. A low sample means active and is reported as 1. The host never drives the line during data frames.
- R7: Slots map to outputs in a fixed order:
  - Frame 1 maps to `irq_vec[0]`.
  - Frame 2 maps to `irq_vec[1]`.
  - Frame 3 maps to `smi_flag`.
  - Frame m, for m = 4..16, maps to `irq_vec[m-1]`.
  - `irq_vec[2]` always reads 0.
- R8: `irq_vec` and `smi_flag` change only together, in the clock after the last frame's turn-around clock. They hold their previous values throughout a sequence.
- R9: In host-paced mode the line stays released for exactly `IDLE_GAP` clocks (default 4) after the last frame, and then the next host low period begins.
- R10: In wake-up mode, after the first start frame, the line stays released for as long as no peripheral drives it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_quiet | input | 1 | 1 selects wake-up mode, 0 selects host-paced mode; read in idle |
| cfg_ext | input | 3 | Host low-extension count, clamped to 3..7 |
| line_in | input | 1 | Resolved level of the shared line |
| line_oe | output | 1 | Host drives the line when 1 |
| line_out | output | 1 | Level driven when `line_oe` = 1 |
| irq_vec | output | 16 | Interrupt request levels, 1 = active |
| smi_flag | output | 1 | System-management request, 1 = active |

## Verification
The hardest situation to reach is a wake-up-mode takeover that begins in the very first idle clock after a sequence, with a raw extension below the legal range. Both the frame timing and the clamp then meet in one low pulse. The bench reaches it by following the frame schedule from the ports: it counts clocks from the host-high clock, drives the peripheral low the moment the last turn-around ends, and sets `cfg_ext` to 0..2. Random rounds then mix modes, extension values, wake-up delays and request patterns. Directed rounds cover the all-active and all-idle vectors.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOW    = 3'd1,
        ST_HIGH   = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_RECOV  = 3'd4,
        ST_TURN   = 3'd5
    } sirq_state_e;

endpackage

// File: rtl/sirq_ext_clamp.sv
// Clamps the raw host extension count into the legal range.
module sirq_ext_clamp #(
    parameter int EXT_W   = 3,
    parameter int EXT_MIN = 3,
    parameter int EXT_MAX = 7
) (
    input  logic [EXT_W-1:0] raw_ext,
    output logic [EXT_W-1:0] eff_ext
);
    always_comb begin
        if (int'(raw_ext) < EXT_MIN)
            eff_ext = EXT_W'(EXT_MIN);
        else if (int'(raw_ext) > EXT_MAX)
            eff_ext = EXT_W'(EXT_MAX);
        else
            eff_ext = raw_ext;
    end
endmodule

// File: rtl/sirq_frame_ctr.sv
// Data-frame index: cleared on the host-high clock, advanced per turn-around.
module sirq_frame_ctr #(
    parameter int N_FRAMES = 16,
    localparam int FRM_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [FRM_W-1:0] idx,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (adv)
            idx <= idx + 1'b1;
    end

    assign last = (idx == FRM_W'(N_FRAMES - 1));
endmodule

// File: rtl/sirq_slot_capture.sv
// Per-frame shadow capture and atomic commit to the output vector.
module sirq_slot_capture #(
    parameter int N_FRAMES = 16,
    parameter int IRQ_W    = 16,
    parameter int SMI_SLOT = 2,
    localparam int FRM_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [FRM_W-1:0] cap_idx,
    input  logic             line_in,
    input  logic             commit,
    output logic [IRQ_W-1:0] irq_vec,
    output logic             smi_flag
);
    logic [N_FRAMES-1:0] shadow;
    logic [IRQ_W-1:0]    mapped;

    for (genvar f = 0; f < N_FRAMES; f++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow[f] <= 1'b0;
            else if (cap_en && (cap_idx == FRM_W'(f)))
                shadow[f] <= ~line_in;
        end
    end

    for (genvar i = 0; i < IRQ_W; i++) begin : g_map
        if (i == SMI_SLOT || i >= N_FRAMES) begin : g_none
            assign mapped[i] = 1'b0;
        end else begin : g_bit
            assign mapped[i] = shadow[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_vec  <= '0;
            smi_flag <= 1'b0;
        end else if (commit) begin
            irq_vec  <= mapped;
            smi_flag <= shadow[SMI_SLOT];
        end
    end
endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int IRQ_W    = 16,
    parameter int EXT_W    = 3,
    parameter int EXT_MIN  = 3,
    parameter int EXT_MAX  = 7,
    parameter int IDLE_GAP = 4,
    localparam int N_FRAMES = IRQ_W,
    localparam int FRM_W    = $clog2(N_FRAMES),
    localparam int CNT_TOP  = (IDLE_GAP > EXT_MAX) ? IDLE_GAP : EXT_MAX,
    localparam int CNT_W    = $clog2(CNT_TOP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_quiet,
    input  logic [EXT_W-1:0] cfg_ext,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out,
    output logic [IRQ_W-1:0] irq_vec,
    output logic             smi_flag
);
    sirq_state_e      state, nstate;
    logic [CNT_W-1:0] cnt;
    logic             first_pend;
    logic             host_paced;
    logic [EXT_W-1:0] ext_eff;
    logic [FRM_W-1:0] frm_idx;
    logic             frm_last;
    logic             frame_commit;

    sirq_ext_clamp #(
        .EXT_W  (EXT_W),
        .EXT_MIN(EXT_MIN),
        .EXT_MAX(EXT_MAX)
    ) u_clamp (
        .raw_ext(cfg_ext),
        .eff_ext(ext_eff)
    );

    sirq_frame_ctr #(
        .N_FRAMES(N_FRAMES)
    ) u_frm (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == ST_HIGH),
        .adv  ((state == ST_TURN) && !frm_last),
        .idx  (frm_idx),
        .last (frm_last)
    );

    assign frame_commit = (state == ST_TURN) && frm_last;

    sirq_slot_capture #(
        .N_FRAMES(N_FRAMES),
        .IRQ_W   (IRQ_W),
        .SMI_SLOT(2)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (state == ST_SAMPLE),
        .cap_idx (frm_idx),
        .line_in (line_in),
        .commit  (frame_commit),
        .irq_vec (irq_vec),
        .smi_flag(smi_flag)
    );

    // The first start frame after reset is host-paced whatever the mode.
    assign host_paced = !cfg_quiet || first_pend;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // Transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (host_paced)
                    nstate = (cnt == '0) ? ST_LOW : ST_IDLE;
                else
                    nstate = !line_in ? ST_LOW : ST_IDLE;
            end
            ST_LOW:    nstate = (cnt == '0) ? ST_HIGH : ST_LOW;
            ST_HIGH:   nstate = ST_SAMPLE;
            ST_SAMPLE: nstate = ST_RECOV;
            ST_RECOV:  nstate = ST_TURN;
            ST_TURN:   nstate = frm_last ? ST_IDLE : ST_SAMPLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    // Gap / low-period counter and first-frame flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            first_pend <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (nstate == ST_LOW) begin
                        cnt        <= host_paced ? CNT_W'(ext_eff)
                                                 : CNT_W'(ext_eff) - 1'b1;
                        first_pend <= 1'b0;
                    end else if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt != '0)
                        cnt <= cnt - 1'b1;
                end
                ST_TURN: begin
                    if (frm_last)
                        cnt <= CNT_W'(IDLE_GAP - 1);
                end
                default: ;
            endcase
        end
    end

    // Line drive
    always_comb begin
        line_oe  = 1'b0;
        line_out = 1'b1;
        unique case (state)
            ST_LOW: begin
                line_oe  = 1'b1;
                line_out = 1'b0;
            end
            ST_HIGH: begin
                line_oe  = 1'b1;
                line_out = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
    parameter int IRQ_W   = 16,
    parameter int EXT_MIN = 3,
    parameter int EXT_MAX = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_oe,
    input logic             line_out,
    input logic [IRQ_W-1:0] irq_vec,
    input logic             frame_commit
);
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= '0;
        else if (line_oe && !line_out)
            low_run <= (low_run == 8'hff) ? low_run : low_run + 8'd1;
        else
            low_run <= '0;
    end

    // R4
    low_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out) |-> (int'(low_run) < EXT_MAX + 1));

    // R4
    low_len_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |-> (int'(low_run) >= EXT_MIN));

    // R5
    high_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |=> !line_oe);

    // R5
    low_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out) |=> line_oe);

    // R6
    no_drive_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_commit |-> !line_oe);

    // R8
    vec_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_vec) |-> $past(frame_commit));
endmodule

bind sirq_host sirq_host_chk #(
    .IRQ_W  (IRQ_W),
    .EXT_MIN(EXT_MIN),
    .EXT_MAX(EXT_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_oe     (line_oe),
    .line_out    (line_out),
    .irq_vec     (irq_vec),
    .frame_commit(frame_commit)
);

// File: tb/sim_sirq_host.sv
module sim_sirq_host;
    localparam int CLK_P = 10;
    localparam int GAP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_quiet = 1'b0;
    logic [2:0]  cfg_ext = 3'd4;
    logic        periph_low = 1'b0;
    logic        line_in;
    logic        line_oe, line_out;
    logic [15:0] irq_vec;
    logic        smi_flag;

    int          errs = 0;
    int          checks = 0;
    logic [15:0] exp_v = '0;
    logic        exp_s = 1'b0;
    int          seed;

    // Pull-up when nobody drives; peripheral pulls low.
    assign line_in = line_oe ? line_out : ~periph_low;

    always #(CLK_P/2) clk = ~clk;

    sirq_host u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_quiet(cfg_quiet),
        .cfg_ext  (cfg_ext),
        .line_in  (line_in),
        .line_oe  (line_oe),
        .line_out (line_out),
        .irq_vec  (irq_vec),
        .smi_flag (smi_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int clampx(input int e);
        return (e < 3) ? 3 : ((e > 7) ? 7 : e);
    endfunction

    function automatic logic [15:0] map_vec(input logic [15:0] p);
        logic [15:0] r;
        r = p;
        r[2] = 1'b0;
        return r;
    endfunction

    // One full round starting in an idle clock (sampled at a falling edge).
    task automatic run_seq(input bit quiet, input bit boot, input logic [2:0] ext,
                           input logic [15:0] pat, input int wait_n);
        int    n;
        int    exp_low;
        string tag;
        cfg_quiet = quiet;
        cfg_ext   = ext;
        if (quiet && !boot) begin
            for (int i = 0; i < wait_n; i++) begin
                chk(!line_oe, "R10 idle release", int'(line_oe), 0);
                @(negedge clk);
            end
            periph_low = 1'b1;
            @(negedge clk);
            periph_low = 1'b0;
            exp_low = clampx(int'(ext));
            tag = (ext < 3) ? "R4 quiet clamp" : "R3 quiet takeover";
        end else begin
            n = 0;
            while (!line_oe && n < 100) begin
                n++;
                @(negedge clk);
            end
            if (boot) chk(n == 1, "R1 first start", n, 1);
            else      chk(n == GAP, "R9 idle gap", n, GAP);
            exp_low = clampx(int'(ext)) + 1;
            tag = (ext < 3) ? "R4 paced clamp" : "R2 paced low";
        end
        n = 0;
        while (line_oe && !line_out && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_low, tag, n, exp_low);
        chk(line_oe && line_out, "R5 high clock", {line_oe, line_out}, 3);
        @(negedge clk);
        for (int f = 0; f < 16; f++) begin
            periph_low = pat[f];
            chk(!line_oe, "R6 no host drive", int'(line_oe), 0);
            chk(irq_vec == exp_v && smi_flag == exp_s, "R8 hold",
                int'(irq_vec), int'(exp_v));
            @(negedge clk);
            periph_low = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
        exp_v = map_vec(pat);
        exp_s = pat[2];
        chk(irq_vec == exp_v, "R6 R7 vector", int'(irq_vec), int'(exp_v));
        chk(smi_flag == exp_s, "R7 smi slot", int'(smi_flag), int'(exp_s));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        seed = $urandom(32'd4711);
        cfg_quiet = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!line_oe && irq_vec == 0 && !smi_flag, "R1 reset state",
                int'(irq_vec), 0);
        end
        rst_n = 1'b1;
        // R1: host starts even though wake-up mode is selected
        run_seq(1'b1, 1'b1, 3'd4, 16'hffff, 0);
        run_seq(1'b0, 1'b0, 3'd0, 16'h0000, 0);      // R4 low clamp
        run_seq(1'b0, 1'b0, 3'd7, 16'h0004, 0);      // R7 SMI only
        run_seq(1'b1, 1'b0, 3'd1, 16'h8001, 0);      // R3 R4 immediate wake
        run_seq(1'b1, 1'b0, 3'd7, 16'h5aa5, 9);      // R10 long wait
        run_seq(1'b0, 1'b0, 3'd3, 16'hffff, 0);
        for (int r = 0; r < 14; r++) begin
            run_seq(1'($urandom), 1'b0, 3'($urandom), 16'($urandom),
                    int'($urandom % 8));
        end
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule